// File: doc/BRIEF.md
# Stereo PCM Volume Control

This block scales two independent streams of signed 16-bit PCM samples, a left lane and a right lane, by a programmable gain. Each lane has its own 7-bit gain code. The codes form a logarithmic scale in half-decibel steps: code 0 is -20 dB, code 40 (0x28) is unity, and code 80 (0x50) is +20 dB. Any code above 80 is treated as 80. The block converts the code into a linear fixed-point multiplier through a table. The table is computed when the design is elaborated.

Each lane is a two-register pipeline. The first register captures the sample together with the multiplier chosen by the gain code present in the same cycle. The second register holds the rounded, saturated product. The valid strobe of each lane travels with its data, and the two lanes never interact. The block sits between a decimation filter and the logic that packs samples into memory.

Top module: `pcm_volume_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released until a sample arrives, both outputs are 0 and both output valid strobes are low.
- R2: Code 40 (0x28) passes a sample through unchanged.
- R3: For code c in 0..80, the multiplier is M(c) = round(10^((c-40)/40) * 2^14). The output is floor((x*M(c) + 2^13) / 2^14), where x is the input sample.
- R4: A code in the range 81..127 gives exactly the result of code 80.
- R5: A scaled result above 32767 is output as 32767. A scaled result below -32768 is output as -32768.
- R6: An input valid strobe high in cycle n produces exactly one output valid pulse, in cycle n+2. The output valid is low in cycle n+1 unless the input valid was high in cycle n-1.
- R7: A lane's output value holds while no new sample has reached that lane's output stage.
- R8: The gain applied to a sample is the code present in the cycle the sample's valid is high. A code change in any later cycle does not affect that sample.
- R9: Each lane uses only its own sample, valid strobe and gain code. Activity on one lane does not change the other lane's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_l | input | 16 | Left input sample, signed |
| in_l_vld | input | 1 | Left input sample valid |
| in_r | input | 16 | Right input sample, signed |
| in_r_vld | input | 1 | Right input sample valid |
| gain_l | input | 7 | Left gain code, 0.5 dB per step, unity at 40 |
| gain_r | input | 7 | Right gain code, 0.5 dB per step, unity at 40 |
| out_l | output | 16 | Left scaled sample, signed, saturated |
| out_l_vld | output | 1 | Left output valid |
| out_r | output | 16 | Right scaled sample, signed, saturated |
| out_r_vld | output | 1 | Right output valid |

## Verification
Every scaled sample is due two clock edges after the edge that captures its input.

The bench drives each sample half a cycle before that capture edge. It samples at the falling edge after the first following rising edge and requires the valid to be low there. It samples again at the falling edge one cycle later and requires the valid high and the exact value. This pins the latency at two cycles in both directions.

In the tests for R8 and R9, the bench changes the gain code or drives the other lane in the cycle between capture and output. The output sampled one cycle later shows whether that activity leaked into the result.

// File: rtl/pcm_gain_pkg.sv
package pcm_gain_pkg;
    parameter int SAMPLE_W = 16;
    parameter int CODE_W   = 7;
    parameter int CODE_MAX = 80;
    parameter int CODE_UNITY = 40;
    parameter int FRAC_W   = 14;
    parameter int MULT_W   = FRAC_W + 4;
    parameter int PROD_W   = SAMPLE_W + MULT_W + 1;
    parameter int LANES    = 2;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic [MULT_W-1:0]          mult_t;

    typedef struct packed {
        logic    stg1_vld;
        sample_t stg1_smp;
        mult_t   stg1_mult;
        logic    out_vld;
        sample_t out_smp;
    } lane_state_t;

    // Linear multiplier for one half-decibel code, rounded to nearest.
    function automatic mult_t code_to_mult(input int code);
        real lin;
        lin = 10.0 ** ((code - CODE_UNITY) / 40.0);
        return mult_t'($rtoi(lin * (2.0 ** FRAC_W) + 0.5));
    endfunction
endpackage

// File: rtl/pcm_gain_lut.sv
module pcm_gain_lut
    import pcm_gain_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output mult_t             mult
);
    localparam int TBL_N = CODE_MAX + 1;

    mult_t             tbl [TBL_N];
    logic [CODE_W-1:0] code_clamped;

    for (genvar i = 0; i < TBL_N; i++) begin : g_tbl
        localparam mult_t ENTRY = code_to_mult(i);
        assign tbl[i] = ENTRY;
    end

    always_comb begin
        code_clamped = (int'(code) > CODE_MAX) ? CODE_W'(CODE_MAX) : code;
        mult         = tbl[code_clamped];
    end
endmodule

// File: rtl/pcm_gain_lane.sv
module pcm_gain_lane
    import pcm_gain_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  sample_t           in_smp,
    input  logic              in_vld,
    input  logic [CODE_W-1:0] gain_code,
    output sample_t           out_smp,
    output logic              out_vld
);
    localparam mult_t MULT_MIN   = code_to_mult(0);
    localparam mult_t MULT_MAX   = code_to_mult(CODE_MAX);
    localparam mult_t MULT_UNITY = code_to_mult(CODE_UNITY);
    localparam logic signed [PROD_W-1:0] RND_HALF = PROD_W'(1) <<< (FRAC_W - 1);
    localparam logic signed [PROD_W-1:0] POS_LIM  = PROD_W'((1 << (SAMPLE_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] NEG_LIM  = -(PROD_W'(1) <<< (SAMPLE_W - 1));

    lane_state_t st_d, st_q;
    mult_t       lut_mult;
    logic signed [PROD_W-1:0] prod, rounded, scaled;

    pcm_gain_lut u_lut (
        .code (gain_code),
        .mult (lut_mult)
    );

    always_comb begin
        st_d    = st_q;
        prod    = PROD_W'(st_q.stg1_smp) * $signed({1'b0, st_q.stg1_mult});
        rounded = prod + RND_HALF;
        scaled  = rounded >>> FRAC_W;

        st_d.stg1_vld = in_vld;
        if (in_vld) begin
            st_d.stg1_smp  = in_smp;
            st_d.stg1_mult = lut_mult;
        end

        st_d.out_vld = st_q.stg1_vld;
        if (st_q.stg1_vld) begin
            if (scaled > POS_LIM)      st_d.out_smp = sample_t'(POS_LIM);
            else if (scaled < NEG_LIM) st_d.out_smp = sample_t'(NEG_LIM);
            else                       st_d.out_smp = sample_t'(scaled);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_smp = st_q.out_smp;
    assign out_vld = st_q.out_vld;

    // R6
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.stg1_vld |=> out_vld);
    // R6
    vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.stg1_vld |=> !out_vld);
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.stg1_vld |=> $stable(out_smp));
    // R2
    unity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stg1_vld && st_q.stg1_mult == MULT_UNITY) |=> out_smp == $past(st_q.stg1_smp));
    // R5
    sign_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stg1_vld && st_q.stg1_smp >= 0) |=> out_smp >= 0);
    // R5
    sign_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stg1_vld && st_q.stg1_smp < 0) |=> out_smp <= 0);
    // R4
    mult_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.stg1_vld |-> (st_q.stg1_mult >= MULT_MIN && st_q.stg1_mult <= MULT_MAX));
endmodule

// File: rtl/pcm_volume_ctrl.sv
module pcm_volume_ctrl
    import pcm_gain_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] in_l,
    input  logic                in_l_vld,
    input  logic [SAMPLE_W-1:0] in_r,
    input  logic                in_r_vld,
    input  logic [CODE_W-1:0]   gain_l,
    input  logic [CODE_W-1:0]   gain_r,
    output logic [SAMPLE_W-1:0] out_l,
    output logic                out_l_vld,
    output logic [SAMPLE_W-1:0] out_r,
    output logic                out_r_vld
);
    sample_t           smp_in  [LANES];
    sample_t           smp_out [LANES];
    logic              vld_in  [LANES];
    logic              vld_out [LANES];
    logic [CODE_W-1:0] codes   [LANES];

    assign smp_in[0] = in_l;     assign smp_in[1] = in_r;
    assign vld_in[0] = in_l_vld; assign vld_in[1] = in_r_vld;
    assign codes[0]  = gain_l;   assign codes[1]  = gain_r;

    // R9: one independent lane per channel
    for (genvar ch = 0; ch < LANES; ch++) begin : g_lane
        pcm_gain_lane u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_smp    (smp_in[ch]),
            .in_vld    (vld_in[ch]),
            .gain_code (codes[ch]),
            .out_smp   (smp_out[ch]),
            .out_vld   (vld_out[ch])
        );
    end

    assign out_l     = smp_out[0];
    assign out_l_vld = vld_out[0];
    assign out_r     = smp_out[1];
    assign out_r_vld = vld_out[1];
endmodule

// File: tb/tb_pcm_volume_ctrl.sv
module tb_pcm_volume_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] in_l, in_r, out_l, out_r;
    logic        in_l_vld, in_r_vld, out_l_vld, out_r_vld;
    logic [6:0]  gain_l, gain_r;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pcm_volume_ctrl dut (.*);

    function automatic int expect_val(input int x, input int code);
        int     c;
        longint m, p;
        c = (code > 80) ? 80 : code;
        m = longint'($rtoi((10.0 ** ((c - 40) / 40.0)) * 16384.0 + 0.5));
        p = (longint'(x) * m + 64'sd8192) >>> 14;
        if (p > 32767)  p = 32767;
        if (p < -32768) p = -32768;
        return int'(p);
    endfunction

    task automatic check(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    // drive one sample at the negedge, then verify the two-cycle timing and the value
    task automatic run_sample(input string req, input bit left, input int x, input int code);
        @(negedge clk);
        if (left) begin in_l = 16'(x); in_l_vld = 1'b1; gain_l = 7'(code); end
        else      begin in_r = 16'(x); in_r_vld = 1'b1; gain_r = 7'(code); end
        @(negedge clk);
        in_l_vld = 1'b0; in_r_vld = 1'b0;
        check({req, " valid low at +1"}, left ? int'(out_l_vld) : int'(out_r_vld), 0);
        @(negedge clk);
        check({req, " R6 valid at +2"}, left ? int'(out_l_vld) : int'(out_r_vld), 1);
        check(req, left ? int'($signed(out_l)) : int'($signed(out_r)), expect_val(x, code));
    endtask

    task automatic t_reset();
        check("R1 out_l", int'(out_l), 0);
        check("R1 out_r", int'(out_r), 0);
        check("R1 vld", int'(out_l_vld) + int'(out_r_vld), 0);
    endtask

    task automatic t_unity();
        run_sample("R2 left", 1, 12345, 40);
        check("R2 identity", int'($signed(out_l)), 12345);
        run_sample("R2 right", 0, -321, 40);
        check("R2 identity r", int'($signed(out_r)), -321);
    endtask

    task automatic t_mapping();
        run_sample("R3 code0", 1, 10000, 0);
        run_sample("R3 code1", 1, -10000, 1);
        run_sample("R3 code39", 0, 777, 39);
        run_sample("R3 code60", 0, -1500, 60);
        run_sample("R3 code80", 1, 3000, 80);
        run_sample("R3 odd", 1, -7, 41);
    endtask

    task automatic t_clamp();
        run_sample("R4 code81", 1, 1234, 81);
        check("R4 eq80", int'($signed(out_l)), expect_val(1234, 80));
        run_sample("R4 code127", 0, -2222, 127);
        check("R4 eq80 r", int'($signed(out_r)), expect_val(-2222, 80));
    endtask

    task automatic t_saturate();
        run_sample("R5 pos", 1, 20000, 80);
        check("R5 pos limit", int'($signed(out_l)), 32767);
        run_sample("R5 neg", 0, -32768, 50);
        check("R5 neg limit", int'($signed(out_r)), -32768);
    endtask

    task automatic t_hold();
        logic [15:0] held;
        held = out_l;
        repeat (5) @(negedge clk);
        check("R7 hold value", int'(out_l), int'(held));
        check("R7 valid low", int'(out_l_vld), 0);
    endtask

    task automatic t_gain_change();
        @(negedge clk);
        in_l = 16'(5000); in_l_vld = 1'b1; gain_l = 7'd30;
        @(negedge clk);
        in_l_vld = 1'b0; gain_l = 7'd70;
        @(negedge clk);
        check("R8 old gain kept", int'($signed(out_l)), expect_val(5000, 30));
        // back-to-back samples with different codes
        in_l = 16'(4000); in_l_vld = 1'b1; gain_l = 7'd45;
        @(negedge clk);
        in_l = 16'(-4000); gain_l = 7'd20;
        @(negedge clk);
        in_l_vld = 1'b0;
        check("R8 first of pair", int'($signed(out_l)), expect_val(4000, 45));
        check("R6 pair valid 1", int'(out_l_vld), 1);
        @(negedge clk);
        check("R8 second of pair", int'($signed(out_l)), expect_val(-4000, 20));
        check("R6 pair valid 2", int'(out_l_vld), 1);
        @(negedge clk);
        check("R6 single pulse", int'(out_l_vld), 0);
    endtask

    task automatic t_independent();
        logic [15:0] r_before;
        run_sample("R9 setup right", 0, 900, 40);
        r_before = out_r;
        @(negedge clk);
        in_l = 16'(-20000); in_l_vld = 1'b1; gain_l = 7'd80; gain_r = 7'd0;
        @(negedge clk);
        in_l_vld = 1'b0;
        @(negedge clk);
        check("R9 left value", int'($signed(out_l)), -32768);
        check("R9 right untouched", int'(out_r), int'(r_before));
        check("R9 right vld low", int'(out_r_vld), 0);
    endtask

    initial begin
        rst_n = 1'b0;
        in_l = '0; in_r = '0; in_l_vld = 1'b0; in_r_vld = 1'b0;
        gain_l = 7'd40; gain_r = 7'd40;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unity();
        t_mapping();
        t_clamp();
        t_saturate();
        t_hold();
        t_gain_change();
        t_independent();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule